// File: doc/BRIEF.md
# NCO Variable-Rate Strobe Generator

This block is a phase-accumulator numerically controlled oscillator. It runs from one fixed system clock. On every enabled cycle it adds a programmable step word to an N-bit phase register. The carry out of that addition marks a wrap, and the block turns it into a strobe one clock cycle long. The average strobe rate is f_clk × step / 2^N, so a change to the step word retunes the rate in fine steps while the clock frequency stays fixed.

The wrap strobe has cycle-to-cycle jitter, because the number of cycles between wraps is not constant unless the step divides 2^N. The wraps therefore also drive a chain of M divide-by-2 stages, and all M stages are outputs. Each further stage halves the rate and makes the jitter smaller relative to its period. Downstream logic can sample on the strobe, or use a divided output when an even rate matters more than resolution.

Top module: `nco_strobe_gen`

## Requirements
- R1: When `rst_n` is low at a rising clock edge, `phase`, `strobe` and every bit of `div_out` are zero after that edge, whatever the other inputs are.
- R2: After each rising edge at which `enable` is high, `phase` equals (previous `phase` + `step`) mod 2^ACC_W.
- R3: `strobe` is high for exactly the cycle that follows an enabled addition whose ACC_W-bit sum overflowed (carry out set). In every other cycle it is low.
- R4: A `step` of zero never raises `strobe`. A `step` of 2^ACC_W − 1 raises `strobe` after every enabled addition except when the phase before the addition is zero.
- R5: `step` is sampled at every enabled edge. A new value applies to the very next addition and continues from the current phase, which is not cleared.
- R6: `div_out` is the count of wraps mod 2^DIV_STAGES, with bit 0 the fastest stage. Stage k (bit k−1) toggles once per 2^(k−1) wraps, at the same edge that raises `strobe`.
- R7: While `enable` is low, `phase` and `div_out` hold their values and `strobe` is low.
- R8: Starting from phase zero with a constant step S, exactly S strobes occur over 2^ACC_W enabled cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, fixed frequency |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Advance the accumulator on this edge |
| step | input | ACC_W | Tuning increment added to the phase each enabled cycle |
| strobe | output | 1 | One-cycle pulse after each accumulator wrap |
| phase | output | ACC_W | Current accumulator value |
| div_out | output | DIV_STAGES | Divide-by-2 chain outputs; bit 0 is the fastest stage |

## Verification
Every result of this block appears one clock after the edge that causes it. `phase`, `strobe` and `div_out` all come from registers that load at the edge where `enable`, `step` and `rst_n` are sampled, so no output has a longer latency. The driver sets the inputs at a falling edge and pushes into the queue the state that a model built from the requirements predicts for after the next rising edge. The monitor pops that item 2 ns after the rising edge and compares all three outputs, so each comparison is made exactly one edge after its stimulus. The R8 rate check counts the strobes that the monitor observes across a full phase period.

// File: rtl/nco_pkg.sv
// nco_pkg: default sizes shared by the NCO strobe generator and its bench.
// Assumes nothing; it only holds constants.
package nco_pkg;
    localparam int unsigned DEF_ACC_W      = 24;
    localparam int unsigned DEF_DIV_STAGES = 4;
endpackage

// File: rtl/nco_phase_accum.sv
// nco_phase_accum: N-bit phase register that adds a step word on enabled
// cycles. It exposes the combinational wrap (enable & carry) for same-edge
// consumers and a registered one-cycle strobe.
// Assumes: synchronous active-low reset; step may change on any cycle.
module nco_phase_accum #(
    parameter int unsigned ACC_W = nco_pkg::DEF_ACC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [ACC_W-1:0] step,
    output logic [ACC_W-1:0] phase_q,
    output logic             wrap_now,
    output logic             wrap_q
);
    localparam int unsigned SUM_W = ACC_W + 1;

    logic [SUM_W-1:0] sum_ext;

    // Widened sum: the top bit is the carry out of the phase addition.
    always_comb begin
        sum_ext  = {1'b0, phase_q} + {1'b0, step};
        wrap_now = enable & sum_ext[ACC_W];
    end

    // Phase register and registered wrap strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
            wrap_q  <= 1'b0;
        end else if (enable) begin
            phase_q <= sum_ext[ACC_W-1:0];
            wrap_q  <= sum_ext[ACC_W];
        end else begin
            wrap_q  <= 1'b0;
        end
    end

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> ($stable(phase_q) && !wrap_q)); // R7

    AST_ZERO_STEP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && step == '0) |=> !wrap_q); // R4
endmodule

// File: rtl/nco_div_chain.sv
// nco_div_chain: ripple-free chain of divide-by-2 stages driven by a
// wrap pulse. Stage i toggles when the wrap arrives and all lower stages
// are high, so the chain holds the wrap count mod 2^STAGES.
// Assumes: wrap_in is already gated by the accumulator enable.
module nco_div_chain #(
    parameter int unsigned STAGES = nco_pkg::DEF_DIV_STAGES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wrap_in,
    output logic [STAGES-1:0] stage_q
);
    logic [STAGES:0] tgl;

    // Toggle chain seed: the wrap pulse enables the first stage.
    always_comb tgl[0] = wrap_in;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        // Pass the toggle on only when this stage is high.
        always_comb tgl[i+1] = tgl[i] & stage_q[i];

        // One divide-by-2 flop per stage.
        always_ff @(posedge clk) begin
            if (!rst_n)
                stage_q[i] <= 1'b0;
            else if (tgl[i])
                stage_q[i] <= ~stage_q[i];
        end
    end

    AST_FIRST_STAGE_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_in |=> (stage_q[0] != $past(stage_q[0]))); // R6

    AST_CHAIN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap_in |=> $stable(stage_q)); // R7
endmodule

// File: rtl/nco_strobe_gen.sv
// nco_strobe_gen: top of the NCO variable-rate strobe generator. The
// accumulator wraps at an average rate of f_clk*step/2^ACC_W; each wrap gives a
// one-cycle strobe and advances a divide-by-2 chain that gives lower-jitter rates.
// Assumes: single clock domain, synchronous active-low reset.
module nco_strobe_gen #(
    parameter int unsigned ACC_W      = nco_pkg::DEF_ACC_W,
    parameter int unsigned DIV_STAGES = nco_pkg::DEF_DIV_STAGES
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  enable,
    input  logic [ACC_W-1:0]      step,
    output logic                  strobe,
    output logic [ACC_W-1:0]      phase,
    output logic [DIV_STAGES-1:0] div_out
);
    logic wrap_now;
    logic wrap_q;

    nco_phase_accum #(.ACC_W(ACC_W)) u_accum (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (enable),
        .step    (step),
        .phase_q (phase),
        .wrap_now(wrap_now),
        .wrap_q  (wrap_q)
    );

    nco_div_chain #(.STAGES(DIV_STAGES)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .wrap_in(wrap_now),
        .stage_q(div_out)
    );

    // Strobe output straight from the registered wrap.
    always_comb strobe = wrap_q;

    AST_STROBE_MATCHES_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        enable |=> (strobe == (phase < $past(phase)))); // R3

    AST_STROBE_ADVANCES_DIV: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |-> (div_out[0] != $past(div_out[0]))); // R6

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (phase == '0 && !strobe && div_out == '0)); // R1
endmodule

// File: tb/nco_strobe_gen_tb.sv
// nco_strobe_gen_tb_top: scoreboard bench. The driver sets inputs at a falling
// edge and queues the state the requirements predict after the next rising edge;
// the monitor pops and compares 2 ns after each rising edge.
module nco_strobe_gen_tb_top;
    localparam int unsigned AW = 8;
    localparam int unsigned DS = 4;

    typedef struct {
        logic          strobe;
        logic [AW-1:0] phase;
        logic [DS-1:0] div;
        string         tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          enable = 1'b0;
    logic [AW-1:0] step = '0;
    logic          strobe;
    logic [AW-1:0] phase;
    logic [DS-1:0] div_out;

    exp_t q[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    int   strobe_seen = 0;
    bit   done = 1'b0;

    // Model state, updated from the requirements only.
    logic [AW-1:0] m_phase = '0;
    logic [DS-1:0] m_div = '0;

    always #5 clk = ~clk;

    nco_strobe_gen #(.ACC_W(AW), .DIV_STAGES(DS)) dut_i (
        .clk(clk), .rst_n(rst_n), .enable(enable), .step(step),
        .strobe(strobe), .phase(phase), .div_out(div_out)
    );

    // Driver: apply one cycle of stimulus and queue its expected result.
    task automatic drive(input logic r_n, input logic en, input logic [AW-1:0] s,
                         input string tag);
        exp_t e;
        logic [AW:0] sum;
        @(negedge clk);
        rst_n = r_n; enable = en; step = s;
        e.strobe = 1'b0;
        if (!r_n) begin
            m_phase = '0; m_div = '0;
        end else if (en) begin
            sum = {1'b0, m_phase} + {1'b0, s};
            m_phase = sum[AW-1:0];
            e.strobe = sum[AW];
            if (sum[AW]) m_div = m_div + 1'b1;
        end
        e.phase = m_phase; e.div = m_div; e.tag = tag;
        q.push_back(e);
    endtask

    // Monitor: compare design outputs one edge after each stimulus.
    always @(posedge clk) begin
        #2;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            n_cmp++;
            if (strobe) strobe_seen++;
            if (strobe !== e.strobe || phase !== e.phase || div_out !== e.div) begin
                n_bad++;
                $display("FAIL %s: got strobe=%0b phase=%0h div=%0h exp strobe=%0b phase=%0h div=%0h",
                         e.tag, strobe, phase, div_out, e.strobe, e.phase, e.div);
            end
        end
    end

    task automatic drain();
        while (q.size() > 0) @(posedge clk);
        repeat (2) @(posedge clk);
    endtask

    initial begin
        // R1: reset from power-up
        drive(1'b0, 1'b1, 8'h55, "R1 reset");
        drive(1'b0, 1'b0, 8'h00, "R1 reset");
        // R2 R3 R6: regular step
        for (int i = 0; i < 12; i++) drive(1'b1, 1'b1, 8'h40, "R2/R3/R6 step 0x40");
        // R2 R3: uneven step that gives jittery wraps
        for (int i = 0; i < 20; i++) drive(1'b1, 1'b1, 8'h5B, "R3/R6 step 0x5B");
        // R4: zero step stays quiet
        for (int i = 0; i < 6; i++) drive(1'b1, 1'b1, 8'h00, "R4 zero step");
        // R7: enable low holds everything even with a large step
        for (int i = 0; i < 5; i++) drive(1'b1, 1'b0, 8'hFF, "R7 idle hold");
        // R5: step change mid-run keeps phase
        for (int i = 0; i < 3; i++) drive(1'b1, 1'b1, 8'h30, "R5 before change");
        for (int i = 0; i < 6; i++) drive(1'b1, 1'b1, 8'h07, "R5 after change");
        // R1: reset from a nonzero state
        drive(1'b0, 1'b1, 8'h11, "R1 reset mid-run");
        // R4: maximum step from phase zero
        for (int i = 0; i < 20; i++) drive(1'b1, 1'b1, 8'hFF, "R4 max step");
        drain();
        // R8: full period with step 0x25 from phase zero
        drive(1'b0, 1'b0, 8'h00, "R8 reset");
        drain();
        strobe_seen = 0;
        for (int i = 0; i < (1 << AW); i++) drive(1'b1, 1'b1, 8'h25, "R8 rate run");
        drain();
        n_cmp++;
        if (strobe_seen != 8'h25) begin
            n_bad++;
            $display("FAIL R8 strobe count: got %0d exp %0d", strobe_seen, 8'h25);
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule